// File: doc/BRIEF.md
# Configurable-Trigger Interrupt Aggregator

This block collects sixty-four external interrupt lines and merges them into a single request for a parent interrupt controller. Each line can be given one of four trigger types: rising edge, falling edge, active-high level or active-low level. Before any edge detection, every line passes through a synchronizer. Edge events are held in sticky latches until software clears them by writing ones. Level events follow the synchronized input.

Software reaches the block through a simple word-addressed 32-bit bus: a valid strobe, a write flag, an address and write data. Read data is registered and appears one cycle after the read. The lines are grouped into two 32-bit banks: bank 0 holds lines 0 to 31 and bank 1 holds lines 32 to 63. Each bank has a group of control words (masked status, raw status, enable set and clear, software-force set and clear) and a group of trigger words (edge status, latched edges with acknowledge, trigger readback, trigger set and clear). Every set, clear and acknowledge word acts only on the bits written as one. This lets software change one line without reading the register first.

Top module: `trig_intc`

## Requirements
- R1: After reset, every enable, software-force bit, trigger configuration bit and edge latch is zero, every status word reads 0, and `irqOut` is low.
- R2: A write to enable-set (word 2, bank 1 word 8) enables exactly the lines whose data bits are 1. A write to enable-clear (word 3, bank 1 word 9) disables exactly those lines. Zero bits leave their lines unchanged, and writing all ones to enable-clear disables the whole bank.
- R3: Software-force set (word 4/10) and clear (word 5/11) act bit by bit in the same way. A forced bit reads as pending in raw status (word 1/7) whatever the input is.
- R4: Masked status (word 0/6) equals raw status AND enable. `irqOut` is high exactly while some masked status bit in either bank is 1.
- R5: A line with trigger bits (rise,fall)=(0,0) is active-high level. Its raw bit equals the input as seen after the two-flop synchronizer.
- R6: A line with trigger bits (1,1) is active-low level. Its raw bit is the inverted synchronized input.
- R7: A line with trigger bits (1,0) latches a rising edge. The raw bit and latched-edge bit stay 1 after the input returns low, and a falling edge does not set the latch.
- R8: A line with trigger bits (0,1) latches a falling edge and ignores rising edges.
- R9: Writing ones to the latched-edge word (0x21 for bank 0, 0x29 for bank 1) clears those latches, and zero bits keep their latches. Writing all ones clears every latch in the bank. The edge status word (0x20/0x28) reads latches AND enable.
- R10: Trigger bits are changed only where a written bit is 1, through rise-set 0x24, rise-clear 0x25, fall-set 0x26 and fall-clear 0x27 (bank 1 at 0x2C to 0x2F). They read back at 0x22 (rise) and 0x23 (fall), and at 0x2A and 0x2B for bank 1.
- R11: Bank 1 controls lines 32 to 63 through control words 6 to 11 and trigger words 0x28 to 0x2F. It does not affect bank 0 words.
- R12: Reads of unmapped or write-only words return 0. Writes to status and readback words change no state, and one access raises at most one write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after a read |
| irqLines | input | 64 | Asynchronous interrupt inputs |
| irqOut | output | 1 | Aggregated request to the parent controller |

## Verification
On every cycle, the embedded assertions check four things. The bit-wise set/clear semantics of the enable words hold. An acknowledged latch really drops unless a new edge arrives at the same moment. Latches never rise in a level mode, and the request never appears with all enables off. Only the bench scenarios can show the per-mode input responses through the synchronizer delay and the separation between the two banks. They also cover decoding of unmapped and read-only words, and the full-width disable-all and acknowledge-all writes used at initialisation.

// File: rtl/trig_intc_pkg.sv
package trig_intc_pkg;
  parameter int BANK_W    = 32;
  parameter int NUM_BANKS = 2;
  localparam int NUM_LINES = BANK_W * NUM_BANKS;

  typedef struct packed {
    logic [NUM_BANKS-1:0] enSet;
    logic [NUM_BANKS-1:0] enClr;
    logic [NUM_BANKS-1:0] softSet;
    logic [NUM_BANKS-1:0] softClr;
    logic [NUM_BANKS-1:0] riseSet;
    logic [NUM_BANKS-1:0] riseClr;
    logic [NUM_BANKS-1:0] fallSet;
    logic [NUM_BANKS-1:0] fallClr;
    logic [NUM_BANKS-1:0] edgeAck;
    logic [BANK_W-1:0]    wdata;
  } ctlStrobes_t;
endpackage

// File: rtl/trig_intc_sync.sv
module trig_intc_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg[i] <= '0;
      else if (i == 0) stg[i] <= din;
      else stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/trig_intc_datapath.sv
module trig_intc_datapath
  import trig_intc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  ctlStrobes_t          strb,
  output logic [NUM_LINES-1:0] maskedSt,
  output logic [NUM_LINES-1:0] rawSt,
  output logic [NUM_LINES-1:0] edgeSt,
  output logic [NUM_LINES-1:0] edgeRaw,
  output logic [NUM_LINES-1:0] riseCfg,
  output logic [NUM_LINES-1:0] fallCfg,
  output logic                 irqOut
);
  logic [NUM_LINES-1:0] syncQ, prevQ;
  logic [NUM_LINES-1:0] enAll, softAll, riseAll, fallAll, latchAll;
  logic [NUM_LINES-1:0] edgeMode, edgeHit, levelVal, rawLine, pend;

  trig_intc_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .din(irqLines), .dout(syncQ)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else prevQ <= syncQ;
  end

  // trigger decode: rise^fall selects edge mode; in level mode rise==fall picks polarity
  assign edgeMode = riseAll ^ fallAll;
  assign edgeHit  = (riseAll & ~fallAll & syncQ & ~prevQ)
                  | (~riseAll & fallAll & ~syncQ & prevQ);
  assign levelVal = syncQ ^ riseAll;
  assign rawLine  = (edgeMode & latchAll) | (~edgeMode & levelVal);
  assign pend     = rawLine | softAll;

  assign rawSt    = pend;
  assign maskedSt = pend & enAll;
  assign edgeRaw  = latchAll;
  assign edgeSt   = latchAll & enAll;
  assign riseCfg  = riseAll;
  assign fallCfg  = fallAll;
  assign irqOut   = |maskedSt;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LO = b * BANK_W;
    logic [BANK_W-1:0] enQ, softQ, riseQ, fallQ, latchQ;
    logic [BANK_W-1:0] ackMask;

    assign ackMask = strb.edgeAck[b] ? strb.wdata : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enQ    <= '0;
        softQ  <= '0;
        riseQ  <= '0;
        fallQ  <= '0;
        latchQ <= '0;
      end else begin
        if (strb.enSet[b])        enQ <= enQ | strb.wdata;
        else if (strb.enClr[b])   enQ <= enQ & ~strb.wdata;
        if (strb.softSet[b])      softQ <= softQ | strb.wdata;
        else if (strb.softClr[b]) softQ <= softQ & ~strb.wdata;
        if (strb.riseSet[b])      riseQ <= riseQ | strb.wdata;
        else if (strb.riseClr[b]) riseQ <= riseQ & ~strb.wdata;
        if (strb.fallSet[b])      fallQ <= fallQ | strb.wdata;
        else if (strb.fallClr[b]) fallQ <= fallQ & ~strb.wdata;
        // a fresh edge in the same cycle as its acknowledge is kept
        latchQ <= (latchQ & ~ackMask) | edgeHit[LO +: BANK_W];
      end
    end

    assign enAll[LO +: BANK_W]    = enQ;
    assign softAll[LO +: BANK_W]  = softQ;
    assign riseAll[LO +: BANK_W]  = riseQ;
    assign fallAll[LO +: BANK_W]  = fallQ;
    assign latchAll[LO +: BANK_W] = latchQ;

    p_enset_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
      strb.enSet[b] |=> ((enQ & $past(strb.wdata)) == $past(strb.wdata)));
    p_enclr_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
      strb.enClr[b] |=> ((enQ & $past(strb.wdata)) == '0));
    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
      strb.edgeAck[b] |=> ((latchQ & $past(strb.wdata & ~edgeHit[LO +: BANK_W])) == '0));
    p_latch_only_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> ((latchQ & ~$past(latchQ) & ~$past(edgeMode[LO +: BANK_W])) == '0));
  end

  p_irq_needs_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (|enAll));
endmodule

// File: rtl/trig_intc_ctrl.sv
module trig_intc_ctrl
  import trig_intc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CTRL_BASE = 0,
  parameter int EDGE_BASE = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [BANK_W-1:0]    busWdata,
  input  logic [NUM_LINES-1:0] maskedSt,
  input  logic [NUM_LINES-1:0] rawSt,
  input  logic [NUM_LINES-1:0] edgeSt,
  input  logic [NUM_LINES-1:0] edgeRaw,
  input  logic [NUM_LINES-1:0] riseCfg,
  input  logic [NUM_LINES-1:0] fallCfg,
  output ctlStrobes_t          strb,
  output logic [BANK_W-1:0]    busRdata
);
  localparam int CTRL_STRIDE = 6;
  localparam int EDGE_STRIDE = 8;

  logic              wrAcc;
  logic [BANK_W-1:0] rdNext;

  assign wrAcc = busValid & busWrite;

  always_comb begin
    strb       = '0;
    strb.wdata = busWdata;
    rdNext     = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int k = 0; k < CTRL_STRIDE; k++) begin
        if (busAddr == ADDR_W'(CTRL_BASE + CTRL_STRIDE*b + k)) begin
          case (k)
            0: rdNext = maskedSt[b*BANK_W +: BANK_W];
            1: rdNext = rawSt[b*BANK_W +: BANK_W];
            2: strb.enSet[b]   = wrAcc;
            3: strb.enClr[b]   = wrAcc;
            4: strb.softSet[b] = wrAcc;
            default: strb.softClr[b] = wrAcc;
          endcase
        end
      end
      for (int k = 0; k < EDGE_STRIDE; k++) begin
        if (busAddr == ADDR_W'(EDGE_BASE + EDGE_STRIDE*b + k)) begin
          case (k)
            0: rdNext = edgeSt[b*BANK_W +: BANK_W];
            1: begin
              rdNext = edgeRaw[b*BANK_W +: BANK_W];
              strb.edgeAck[b] = wrAcc;
            end
            2: rdNext = riseCfg[b*BANK_W +: BANK_W];
            3: rdNext = fallCfg[b*BANK_W +: BANK_W];
            4: strb.riseSet[b] = wrAcc;
            5: strb.riseClr[b] = wrAcc;
            6: strb.fallSet[b] = wrAcc;
            default: strb.fallClr[b] = wrAcc;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdata <= '0;
    else if (busValid && !busWrite) busRdata <= rdNext;
  end

  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.enSet, strb.enClr, strb.softSet, strb.softClr, strb.riseSet,
              strb.riseClr, strb.fallSet, strb.fallClr, strb.edgeAck}));
  p_read_no_strobe_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite) |-> ({strb.enSet, strb.enClr, strb.softSet, strb.softClr,
      strb.riseSet, strb.riseClr, strb.fallSet, strb.fallClr, strb.edgeAck} == '0));
endmodule

// File: rtl/trig_intc.sv
module trig_intc
  import trig_intc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int CTRL_BASE   = 0,
  parameter int EDGE_BASE   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [BANK_W-1:0]    busWdata,
  output logic [BANK_W-1:0]    busRdata,
  input  logic [NUM_LINES-1:0] irqLines,
  output logic                 irqOut
);
  ctlStrobes_t          strb;
  logic [NUM_LINES-1:0] maskedSt, rawSt, edgeSt, edgeRaw, riseCfg, fallCfg;

  trig_intc_ctrl #(.ADDR_W(ADDR_W), .CTRL_BASE(CTRL_BASE), .EDGE_BASE(EDGE_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .maskedSt(maskedSt), .rawSt(rawSt),
    .edgeSt(edgeSt), .edgeRaw(edgeRaw), .riseCfg(riseCfg), .fallCfg(fallCfg),
    .strb(strb), .busRdata(busRdata)
  );

  trig_intc_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .strb(strb),
    .maskedSt(maskedSt), .rawSt(rawSt), .edgeSt(edgeSt), .edgeRaw(edgeRaw),
    .riseCfg(riseCfg), .fallCfg(fallCfg), .irqOut(irqOut)
  );
endmodule

// File: tb/tb_trig_intc.sv
`timescale 1ns/1ps
module tb_trig_intc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [63:0] irqLines = '0;
  logic        irqOut;
  logic        rdPend;
  logic        done = 1'b0;
  int          nChecks = 0, nFails = 0;

  logic [7:0]  qAddr[$];
  logic [31:0] qExp[$];
  string       qTag[$];

  always #2.5 clk = ~clk;

  trig_intc dut (.clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqLines(irqLines), .irqOut(irqOut));

  always @(posedge clk) rdPend <= rstN & busValid & ~busWrite;

  // monitor: pops expected read results as they arrive
  always @(negedge clk) begin
    if (rdPend && qExp.size() > 0) begin
      logic [31:0] e; logic [7:0] a; string t;
      e = qExp.pop_front(); a = qAddr.pop_front(); t = qTag.pop_front();
      nChecks++;
      if (busRdata !== e) begin
        nFails++;
        $display("FAIL %s read word %h: got %h expected %h", t, a, busRdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); busValid = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk); busValid = 0; busWrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk); busValid = 1; busWrite = 0; busAddr = a;
    qAddr.push_back(a); qExp.push_back(e); qTag.push_back(t);
    @(negedge clk); busValid = 0;
  endtask

  task automatic chkIrq(input logic e, input string t);
    @(negedge clk);
    nChecks++;
    if (irqOut !== e) begin
      nFails++;
      $display("FAIL %s irqOut: got %b expected %b", t, irqOut, e);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chkIrq(1'b0, "R1");
    rd(8'h00, 0, "R1"); rd(8'h01, 0, "R1"); rd(8'h06, 0, "R1"); rd(8'h07, 0, "R1");
    rd(8'h20, 0, "R1"); rd(8'h21, 0, "R1"); rd(8'h22, 0, "R1"); rd(8'h23, 0, "R1");
    rd(8'h2A, 0, "R1");
    // R10 trigger configuration set/clear
    wr(8'h24, 32'h0000_00F0); wr(8'h26, 32'h0000_00CC);
    rd(8'h22, 32'h0000_00F0, "R10"); rd(8'h23, 32'h0000_00CC, "R10");
    wr(8'h25, 32'h0000_0010);
    rd(8'h22, 32'h0000_00E0, "R10"); rd(8'h23, 32'h0000_00CC, "R10");
    wr(8'h25, 32'hFFFF_FFFF); wr(8'h27, 32'hFFFF_FFFF);
    rd(8'h22, 0, "R10"); rd(8'h23, 0, "R10");
    // R3 software force, R2/R4 enables and masking
    wr(8'h04, 32'h5);
    rd(8'h01, 32'h5, "R3"); rd(8'h00, 0, "R4"); chkIrq(1'b0, "R4");
    wr(8'h02, 32'h4);
    rd(8'h00, 32'h4, "R4"); chkIrq(1'b1, "R4");
    wr(8'h02, 32'h1);
    rd(8'h00, 32'h5, "R2");
    wr(8'h03, 32'h4);
    rd(8'h00, 32'h1, "R2");
    wr(8'h05, 32'h1);
    rd(8'h01, 32'h4, "R3"); rd(8'h00, 0, "R3"); chkIrq(1'b0, "R3");
    wr(8'h05, 32'h4);
    // R5 active-high level on line 3
    wr(8'h02, 32'h8);
    @(negedge clk) irqLines[3] = 1; settle();
    rd(8'h01, 32'h8, "R5"); rd(8'h00, 32'h8, "R5"); chkIrq(1'b1, "R5");
    @(negedge clk) irqLines[3] = 0; settle();
    rd(8'h01, 0, "R5"); chkIrq(1'b0, "R5");
    // R6 active-low level on line 3
    wr(8'h24, 32'h8); wr(8'h26, 32'h8); settle();
    rd(8'h01, 32'h8, "R6"); chkIrq(1'b1, "R6");
    @(negedge clk) irqLines[3] = 1; settle();
    rd(8'h01, 0, "R6"); chkIrq(1'b0, "R6");
    wr(8'h25, 32'h8); wr(8'h27, 32'h8);
    @(negedge clk) irqLines[3] = 0; settle();
    rd(8'h01, 0, "R5");
    // R7 rising edge on line 9
    wr(8'h24, 32'h200); wr(8'h02, 32'h200);
    @(negedge clk) irqLines[9] = 1; settle();
    @(negedge clk) irqLines[9] = 0; settle();
    rd(8'h01, 32'h200, "R7"); rd(8'h21, 32'h200, "R7"); rd(8'h20, 32'h200, "R9");
    chkIrq(1'b1, "R7");
    wr(8'h21, 32'h1);
    rd(8'h21, 32'h200, "R9");
    wr(8'h21, 32'h200);
    rd(8'h21, 0, "R9"); chkIrq(1'b0, "R9");
    @(negedge clk) irqLines[9] = 1; settle();
    wr(8'h21, 32'h200);
    @(negedge clk) irqLines[9] = 0; settle();
    rd(8'h21, 0, "R7"); rd(8'h01, 0, "R7");
    // R8 falling edge on line 12
    wr(8'h26, 32'h1000);
    @(negedge clk) irqLines[12] = 1; settle();
    rd(8'h21, 0, "R8");
    @(negedge clk) irqLines[12] = 0; settle();
    rd(8'h21, 32'h1000, "R8"); rd(8'h01, 32'h1000, "R8");
    wr(8'h21, 32'hFFFF_FFFF);
    rd(8'h21, 0, "R9");
    // R11 bank 1, line 40
    wr(8'h2C, 32'h100); wr(8'h08, 32'h100);
    @(negedge clk) irqLines[40] = 1; settle();
    @(negedge clk) irqLines[40] = 0; settle();
    rd(8'h07, 32'h100, "R11"); rd(8'h06, 32'h100, "R11"); rd(8'h29, 32'h100, "R11");
    rd(8'h2A, 32'h100, "R11"); rd(8'h01, 0, "R11"); rd(8'h21, 0, "R11");
    chkIrq(1'b1, "R11");
    wr(8'h29, 32'hFFFF_FFFF);
    rd(8'h29, 0, "R9"); chkIrq(1'b0, "R9");
    // R12 unmapped, write-only and read-only words
    rd(8'h15, 0, "R12"); rd(8'h1F, 0, "R12"); rd(8'h40, 0, "R12"); rd(8'h02, 0, "R12");
    wr(8'h01, 32'hFFFF_FFFF); wr(8'h20, 32'hFFFF_FFFF); wr(8'h22, 32'hFFFF_FFFF);
    rd(8'h01, 0, "R12"); rd(8'h22, 32'h200, "R12"); rd(8'h23, 32'h1000, "R12");
    rd(8'h00, 0, "R12");
    // R2 disable-all initialisation write
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h00, 32'h209, "R2"); chkIrq(1'b1, "R2");
    wr(8'h03, 32'hFFFF_FFFF);
    rd(8'h00, 0, "R2"); rd(8'h01, 32'hFFFF_FFFF, "R3"); chkIrq(1'b0, "R2");
    repeat (3) @(negedge clk);
    if (qExp.size() != 0) begin
      nChecks++; nFails++;
      $display("FAIL R12 %0d reads unanswered: got pending expected none", qExp.size());
    end
    done = 1;
    finishRun();
  end
endmodule